// File: doc/BRIEF.md
# Erase-Block Protection State Manager

This block holds the write-protection state of every erase block in a flash array. Each block is in one of three states: sealed, open or pinned. A sealed block refuses program and erase. An open block accepts them. A pinned block refuses them like a sealed one, and software commands alone cannot release it. Software sends single-block commands that seal, open or pin a block. A hardware guard input decides whether a pinned block can be released. Whenever the guard drops from high to low, every pinned block goes back to sealed.

Program and erase requests come in with a block index. The block answers each one a cycle later with a grant pulse or a refuse pulse. A refusal sets a sticky error flag, and only a dedicated clear command resets it. Reset and power-down both return every block to sealed. A readback port shows the state of any block, for system-level checks.

Top module: `flash_protect_mgr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every block becomes sealed and `status_err` clears, so after reset every block reads sealed.
- R2: While `pwr_down` is high at a rising edge, every block becomes sealed and block commands are discarded. `status_err` is not affected.
- R3: Block states are encoded on 2 bits as 00 sealed, 01 open and 10 pinned. Opcodes on `cmd_op` are 1 seal, 2 open, 3 pin and 4 clear-status.
- R4: A seal command turns an open block into a sealed block. A seal command aimed at a pinned block leaves it pinned.
- R5: An open command turns a sealed block into an open block. It turns a pinned block into an open block only while `hw_guard` is high. While `hw_guard` is low, the pinned block stays pinned.
- R6: A pin command turns a sealed or an open block into a pinned block.
- R7: On an edge where `hw_guard` is low and was high at the previous edge, every pinned block becomes sealed. For a pinned block, this takes priority over any command aimed at it in the same cycle.
- R8: A request (`op_req`) is answered one cycle later. If the addressed block was open, `op_grant` pulses. Otherwise `op_refuse` pulses. The two never pulse together.
- R9: A refusal sets `status_err`. The flag stays set until a clear-status command. When a refusal and a clear-status command come in the same cycle, the flag stays set.
- R10: `rd_state` shows, combinationally, the stored state of the block selected by `rd_blk`.
- R11: Commands with an opcode of 0, 5, 6 or 7 change no block and leave `status_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Power-down indication, seals every block |
| hw_guard | input | 1 | Hardware guard level; high allows pinned blocks to be released |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_blk | input | BLK_W | Block targeted by the command |
| op_req | input | 1 | Program or erase request strobe |
| op_blk | input | BLK_W | Block targeted by the request |
| op_grant | output | 1 | Request allowed (one cycle after the request) |
| op_refuse | output | 1 | Request refused (one cycle after the request) |
| status_err | output | 1 | Sticky protection-violation flag |
| rd_blk | input | BLK_W | Block selected for readback |
| rd_state | output | 2 | State of the selected block |

## Verification
Several functions can fall in the same cycle, and two pairs matter most. The first is a guard falling edge arriving together with a command to a pinned block. The second is a refusal arriving together with a clear-status command. The directed part of the bench drives each pair into the same cycle on purpose. A long random phase then toggles the guard, power-down, commands and requests independently, so that they collide often. A behavioural reference model in the bench applies the stated priorities: reversion beats the command, and setting the flag beats clearing it. Every cycle, the bench compares the pulses, the flag and the state of every block against that model.

// File: rtl/fpm_pkg.sv
// Shared types for the erase-block protection manager.
// Assumes: state and opcode encodings are fixed and visible to software.
package fpm_pkg;

    // Per-block protection state (2-bit encoding, 11 unused)
    typedef enum logic [1:0] {
        BLK_SEALED = 2'b00,
        BLK_OPEN   = 2'b01,
        BLK_PINNED = 2'b10
    } blk_state_t;

    // Command opcodes; any other value is a no-op
    typedef enum logic [2:0] {
        OPC_NONE  = 3'd0,
        OPC_SEAL  = 3'd1,
        OPC_OPEN  = 3'd2,
        OPC_PIN   = 3'd3,
        OPC_CLEAR = 3'd4
    } opc_t;

    localparam int unsigned ST_W = 2;

endpackage

// File: rtl/fpm_guard_edge.sv
// Registers the hardware guard level and flags its high-to-low transition.
// Assumes: hw_guard is already synchronous to clk.
module fpm_guard_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic guard_in,
    output logic fall_o
);

    logic guard_q;

    // Remember the guard level seen at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) guard_q <= 1'b0;
        else        guard_q <= guard_in;
    end

    // A fall is: high last edge, low now
    always_comb fall_o = guard_q & ~guard_in;

endmodule

// File: rtl/fpm_block_cell.sv
// Holds the protection state of one erase block and applies commands aimed at it.
// Assumes: the guard fall has priority over a command for a pinned block;
//          reset and power-down seal the block.
module fpm_block_cell
    import fpm_pkg::*;
#(
    parameter int unsigned BLK_W = 4,
    parameter int unsigned IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             guard_fall,
    input  logic             guard_hi,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [BLK_W-1:0] cmd_blk,
    output logic [ST_W-1:0]  state_o
);

    localparam logic [BLK_W-1:0] MY_IDX = BLK_W'(IDX);

    blk_state_t cur_q;
    blk_state_t nxt;
    logic       hit;

    // Address decode for this block
    always_comb hit = cmd_valid && (cmd_blk == MY_IDX);

    // Next state: guard reversion first, then the addressed command
    always_comb begin
        nxt = cur_q;
        if (guard_fall && cur_q == BLK_PINNED) begin
            nxt = BLK_SEALED;
        end else if (hit) begin
            case (opc_t'(cmd_op))
                OPC_SEAL: if (cur_q == BLK_OPEN) nxt = BLK_SEALED;
                OPC_OPEN: begin
                    if (cur_q == BLK_SEALED)
                        nxt = BLK_OPEN;
                    else if (cur_q == BLK_PINNED && guard_hi)
                        nxt = BLK_OPEN;
                end
                OPC_PIN:  if (cur_q != BLK_PINNED) nxt = BLK_PINNED;
                default:  nxt = cur_q;
            endcase
        end
    end

    // State register; reset and power-down both seal
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) cur_q <= BLK_SEALED;
        else                    cur_q <= nxt;
    end

    always_comb state_o = cur_q;

endmodule

// File: rtl/fpm_op_gate.sv
// Judges program/erase requests against the stored block states and keeps the sticky error flag.
// Assumes: a request is judged on the state before this cycle's update;
//          setting the flag wins over clearing it in the same cycle.
module fpm_op_gate
    import fpm_pkg::*;
#(
    parameter int unsigned NBLK  = 16,
    parameter int unsigned BLK_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_req,
    input  logic [BLK_W-1:0]     op_blk,
    input  logic [NBLK*ST_W-1:0] st_flat,
    input  logic                 clr_cmd,
    output logic                 grant_o,
    output logic                 refuse_o,
    output logic                 err_o
);

    logic [ST_W-1:0] sel;
    logic            is_open;

    // Pick the state of the requested block
    always_comb begin
        sel     = st_flat[{op_blk, 1'b0} +: ST_W];
        is_open = (sel == BLK_OPEN);
    end

    // Registered verdict pulses and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o  <= 1'b0;
            refuse_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            grant_o  <= op_req && is_open;
            refuse_o <= op_req && !is_open;
            if (op_req && !is_open) err_o <= 1'b1;
            else if (clr_cmd)       err_o <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_protect_mgr.sv
// Top of the erase-block protection manager: one state cell per block,
// a guard edge detector, the request gate and a readback mux.
// Assumes: block count is a power of two no larger than 2**BLK_W.
module flash_protect_mgr
    import fpm_pkg::*;
#(
    parameter int unsigned NBLK  = 16,
    parameter int unsigned BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             hw_guard,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [BLK_W-1:0] cmd_blk,
    input  logic             op_req,
    input  logic [BLK_W-1:0] op_blk,
    output logic             op_grant,
    output logic             op_refuse,
    output logic             status_err,
    input  logic [BLK_W-1:0] rd_blk,
    output logic [1:0]       rd_state
);

    localparam int unsigned FLAT_W = NBLK * ST_W;

    logic              guard_fall;
    logic              clr_cmd;
    logic [FLAT_W-1:0] st_flat;

    // Guard transition detector
    fpm_guard_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .guard_in (hw_guard),
        .fall_o   (guard_fall)
    );

    // One state cell per erase block
    for (genvar g = 0; g < NBLK; g++) begin : g_cell
        fpm_block_cell #(.BLK_W(BLK_W), .IDX(g)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .pwr_down   (pwr_down),
            .guard_fall (guard_fall),
            .guard_hi   (hw_guard),
            .cmd_valid  (cmd_valid),
            .cmd_op     (cmd_op),
            .cmd_blk    (cmd_blk),
            .state_o    (st_flat[g*ST_W +: ST_W])
        );
    end

    // Clear-status command decode
    always_comb clr_cmd = cmd_valid && (cmd_op == OPC_CLEAR);

    // Request gate and sticky flag
    fpm_op_gate #(.NBLK(NBLK), .BLK_W(BLK_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_req   (op_req),
        .op_blk   (op_blk),
        .st_flat  (st_flat),
        .clr_cmd  (clr_cmd),
        .grant_o  (op_grant),
        .refuse_o (op_refuse),
        .err_o    (status_err)
    );

    // Readback of one block's state
    always_comb rd_state = st_flat[{rd_blk, 1'b0} +: ST_W];

endmodule

// File: rtl/fpm_checker.sv
// Temporal checks on the protection manager, attached by bind.
module fpm_checker #(
    parameter int unsigned NBLK  = 16,
    parameter int unsigned BLK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_down,
    input logic              hw_guard,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [BLK_W-1:0]  op_blk,
    input logic              op_grant,
    input logic              op_refuse,
    input logic              status_err,
    input logic [NBLK*2-1:0] st_flat
);

    logic any_pinned;
    logic prev_open;

    // Is any block pinned right now
    always_comb begin
        any_pinned = 1'b0;
        for (int i = 0; i < NBLK; i++)
            if (st_flat[2*i +: 2] == 2'b10) any_pinned = 1'b1;
    end

    // Was the requested block open at the previous edge
    always_ff @(posedge clk)
        prev_open <= (st_flat[{op_blk, 1'b0} +: 2] == 2'b01);

    assert_reset_seals_R1: assert property (@(posedge clk)
        !rst_n |=> (st_flat == '0 && !status_err));

    assert_pwrdown_seals_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (st_flat == '0));

    assert_fall_reverts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hw_guard) && !pwr_down && !(cmd_valid && cmd_op == 3'd3)) |=> !any_pinned);

    assert_verdict_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_grant && op_refuse));

    assert_grant_needs_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_grant |-> prev_open);

    assert_refuse_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_refuse |-> status_err);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_err && !(cmd_valid && cmd_op == 3'd4)) |=> status_err);

endmodule

bind flash_protect_mgr fpm_checker #(.NBLK(NBLK), .BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .hw_guard   (hw_guard),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .op_blk     (op_blk),
    .op_grant   (op_grant),
    .op_refuse  (op_refuse),
    .status_err (status_err),
    .st_flat    (st_flat)
);

// File: tb/flash_protect_mgr_test.sv
`timescale 1ns/100ps
module flash_protect_mgr_test;

    localparam int NB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic       hw_guard = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [3:0] cmd_blk = 4'd0;
    logic       op_req = 1'b0;
    logic [3:0] op_blk = 4'd0;
    logic [3:0] rd_blk = 4'd0;
    logic       op_grant, op_refuse, status_err;
    logic [1:0] rd_state;

    int vectors = 0;
    int miscompares = 0;
    string tag = "R1";

    // Reference model state
    int m[NB];
    bit eg, er, merr, gq;

    flash_protect_mgr #(.NBLK(NB)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .hw_guard(hw_guard),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
        .op_req(op_req), .op_blk(op_blk),
        .op_grant(op_grant), .op_refuse(op_refuse), .status_err(status_err),
        .rd_blk(rd_blk), .rd_state(rd_state)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Behavioural model, one update per rising edge
    always @(posedge clk) begin
        bit fall;
        if (!rst_n) begin
            foreach (m[i]) m[i] = 0;          // R1
            eg = 0; er = 0; merr = 0; gq = 0;
        end else begin
            eg = op_req && (m[op_blk] == 1);  // R8
            er = op_req && (m[op_blk] != 1);
            if (er) merr = 1;                  // R9: set beats clear
            else if (cmd_valid && cmd_op == 3'd4) merr = 0;
            fall = gq && !hw_guard;
            gq = hw_guard;
            if (pwr_down) begin
                foreach (m[i]) m[i] = 0;      // R2
            end else begin
                foreach (m[i]) begin
                    if (fall && m[i] == 2) m[i] = 0;    // R7 priority
                    else if (cmd_valid && cmd_blk == i) begin
                        if (cmd_op == 3'd1 && m[i] == 1) m[i] = 0;              // R4
                        else if (cmd_op == 3'd2 && m[i] == 0) m[i] = 1;         // R5
                        else if (cmd_op == 3'd2 && m[i] == 2 && hw_guard) m[i] = 1;
                        else if (cmd_op == 3'd3 && m[i] != 2) m[i] = 2;         // R6
                        // R11: other opcodes leave the block alone
                    end
                end
            end
        end
    end

    // Compare outputs and sweep every block through the readback port (R10, R3)
    task automatic compare();
        vectors++;
        if (op_grant !== eg) begin
            miscompares++;
            $display("FAIL R8 (%s): op_grant got %0b exp %0b", tag, op_grant, eg);
        end
        if (op_refuse !== er) begin
            miscompares++;
            $display("FAIL R8 (%s): op_refuse got %0b exp %0b", tag, op_refuse, er);
        end
        if (status_err !== merr) begin
            miscompares++;
            $display("FAIL R9 (%s): status_err got %0b exp %0b", tag, status_err, merr);
        end
        for (int i = 0; i < NB; i++) begin
            rd_blk = 4'(i);
            #0.2;
            if (rd_state !== 2'(m[i])) begin
                miscompares++;
                $display("FAIL R10 (%s): block %0d state got %0d exp %0d", tag, i, rd_state, m[i]);
            end
        end
    endtask

    // One clock of stimulus: check at the falling edge, then drive
    task automatic step(input bit rn, input bit pd, input bit g,
                        input bit v, input int op, input int b,
                        input bit rq, input int ob);
        @(negedge clk);
        compare();
        rst_n = rn; pwr_down = pd; hw_guard = g;
        cmd_valid = v; cmd_op = 3'(op); cmd_blk = 4'(b);
        op_req = rq; op_blk = 4'(ob);
    endtask

    task automatic cmd(input int op, input int b, input bit g);
        step(1, 0, g, 1, op, b, 0, 0);
    endtask

    task automatic req(input int b, input bit g);
        step(1, 0, g, 0, 0, 0, 1, b);
    endtask

    task automatic idle(input bit g);
        step(1, 0, g, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: expiry counts as a failed check
    initial begin
        #1500000;
        miscompares++;
        $display("FAIL watchdog: run hung, got timeout exp completion");
        finish_run();
    end

    initial begin
        // R1: reset seals everything
        tag = "R1";
        step(0, 0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        idle(1); idle(1);

        // R8 R9: request to sealed block is refused and flags
        tag = "R9 refuse";
        req(3, 1); idle(1); idle(1);
        tag = "R9 clear";
        cmd(4, 0, 1); idle(1);

        // R5: open then grant
        tag = "R5 open";
        cmd(2, 3, 1); req(3, 1); idle(1);
        // R4: seal then refuse
        tag = "R4 seal";
        cmd(1, 3, 1); req(3, 1); idle(1); cmd(4, 0, 1);

        // R6: pin from sealed and from open
        tag = "R6 pin";
        cmd(3, 3, 1); cmd(2, 4, 1); cmd(3, 4, 1); req(4, 1); idle(1);
        // R4: seal aimed at pinned block is ignored
        tag = "R4 seal pinned";
        cmd(1, 4, 1); idle(1);

        // R7: guard falls, pinned blocks revert
        tag = "R7 fall";
        idle(0); idle(0);

        // R5: pinned while guard low ignores open; releases once high
        tag = "R5 guard low";
        cmd(3, 6, 0); cmd(2, 6, 0); idle(0);
        tag = "R5 guard high";
        idle(1); cmd(2, 6, 1); idle(1);

        // R7: fall in the same cycle as a command to a pinned block
        tag = "R7 priority";
        cmd(3, 7, 1); cmd(3, 8, 1); cmd(2, 7, 0); idle(0); idle(1);
        cmd(3, 9, 1); cmd(3, 9, 0); idle(0); idle(1);

        // R9: refusal and clear in the same cycle keep the flag
        tag = "R9 same cycle";
        step(1, 0, 1, 1, 4, 0, 1, 2); idle(1); cmd(4, 0, 1); idle(1);

        // R2: power-down seals open and pinned blocks, flag untouched
        tag = "R2 power-down";
        cmd(2, 10, 1); cmd(3, 11, 1); req(0, 1);
        step(1, 1, 1, 1, 2, 12, 0, 0); idle(1); idle(1);

        // R11: unused opcodes do nothing
        tag = "R11 unused op";
        cmd(2, 2, 1);
        cmd(0, 2, 1); cmd(5, 2, 1); cmd(6, 2, 1); cmd(7, 2, 1); idle(1);

        // R3 R7 R8 R9: mixed random traffic with collisions
        tag = "R3 mixed";
        for (int k = 0; k < 4000; k++) begin
            bit g;
            g = hw_guard;
            if (($urandom % 8) == 0) g = ~g;
            step(($urandom % 500) != 0, ($urandom % 64) == 0, g,
                 ($urandom % 3) != 0, int'($urandom % 8), int'($urandom % NB),
                 ($urandom % 2) == 0, int'($urandom % NB));
        end
        idle(1); idle(1);
        finish_run();
    end

endmodule